// File: doc/BRIEF.md
# Cascadable Eight-Level Priority Interrupt Controller

This block gathers eight interrupt request lines, ranks them with level 0 as most urgent, and tells a processor when an unmasked request outranks everything already being serviced. Software talks to it over a byte-wide register interface with two addresses. Address 0 is the command port. Address 1 is the data and mask port. A short sequence of setup words selects the vector base, the cascade arrangement and the end-of-service mode. After that sequence, the block takes mask writes, end-of-service commands and read-back selection commands.

When the processor pulses `ack`, the winning request moves from the request register into the in-service register. One cycle later the block returns an 8-bit vector, which is the base with the level in the low three bits. If the winning level has a downstream controller, a master does not return a vector; it names that level on the cascade outputs instead. A slave answers an acknowledge only when the cascade identifier presented to it matches its own. If the request has disappeared by the time it is acknowledged, the block returns the base with level 7 and marks nothing in service.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset the block is uninitialised. `int_out`, `vec_valid` and `cas_drive` are 0, and both ports read 0x00.
- R2: A command-port write with bit 4 set starts setup. It clears the mask, request and in-service registers and selects request read-back. Bit 0 of that byte asks for a mode word. The following data-port writes load the vector base (bits 7:3), then the cascade word, then the mode word if one was asked for. After that, data-port writes load the mask, which reads back at address 1.
- R3: A mask bit of 1 stops the matching request from raising `int_out`. The request stays pending and fires once it is unmasked.
- R4: `int_out` is 1 only when some unmasked pending level is strictly more urgent (lower number) than every in-service level.
- R5: One cycle after `ack`, `vec_valid` is 1 and `vector` = base | level. In the same edge, the most urgent eligible level moves from the request register to the in-service register.
- R6: A command write of 0x60+n clears in-service bit n.
- R7: A command write of 0x20 clears the most urgent in-service bit that is set.
- R8: A command write of 0x0B makes address 0 read the in-service register. A command write of 0x0A makes it read the request register.
- R9: An `ack` with no eligible request returns base | 7 and leaves the in-service register unchanged. This holds even when level 7 is masked.
- R10: A mode word with bit 1 set selects automatic end of service. In that mode an acknowledge sets no in-service bit.
- R11: On a master (`is_master`=1), acknowledging a level whose cascade-word bit is set drives `cas_drive`=1 and `cas_id_out`=level, with `vec_valid`=0. The level still enters service.
- R12: A slave (`is_master`=0) acts on `ack` only when `cas_id_in` equals bits 2:0 of its cascade word. Otherwise it returns no vector and changes no register.
- R13: Requests are rising-edge detected. An input that is already high when setup starts needs a new rising edge to be recorded. A recorded request is dropped when its input falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 1 | 0 = command port, 1 = data/mask port |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` |
| irq_in | input | 8 | Request lines, level 0 most urgent |
| int_out | output | 1 | Interrupt to processor |
| ack | input | 1 | One-cycle acknowledge strobe |
| is_master | input | 1 | 1 = master, 0 = slave |
| cas_id_in | input | 3 | Cascade identifier seen by a slave |
| cas_drive | output | 1 | Master routes this acknowledge downstream |
| cas_id_out | output | 3 | Level routed downstream |
| vec_valid | output | 1 | `vector` valid |
| vector | output | 8 | Returned vector |

## Verification
An acknowledge and an end-of-service command can land on the same clock edge. One sets an in-service bit while the other clears a different one. The bench provokes this with level 4 in service and level 0 pending. It pulses `ack` in the same cycle as a write of 0x64, then expects vector 0x20 and an in-service read-back of exactly 0x01. A request vanishing just before its acknowledge is a second collision. It is judged by vector base|7 and an unchanged in-service register.

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic [7:0] irq_in,
  output logic       int_out,
  input  logic       ack,
  input  logic       is_master,
  input  logic [2:0] cas_id_in,
  output logic       cas_drive,
  output logic [2:0] cas_id_out,
  output logic       vec_valid,
  output logic [7:0] vector
);
  typedef enum logic [1:0] {S_RDY, S_BASE, S_CAS, S_MODE} seq_t;

  seq_t       seq;
  logic       inited, need_mode, aeoi, sel_isr;
  logic [7:0] imr, irr, isr, prev_in, cas_word;
  logic [4:0] base;

  function automatic logic [2:0] enc(input logic [7:0] oh);
    enc = 3'd0;
    for (int i = 0; i < 8; i++)
      if (oh[i]) enc = 3'(i);
  endfunction

  logic       ready;
  logic [7:0] pending, isr_low, above, cand, win_oh, eoi_mask, set_isr, rise;
  logic       cmd_wr, dat_wr, init_cmd, ocw_ok, seoi, neoi, rsel;
  logic       ack_take, spurious, to_slave;
  logic [2:0] win_lvl;

  assign ready    = inited && seq == S_RDY;
  assign pending  = irr & ~imr;
  assign isr_low  = isr & (~isr + 8'd1);
  assign above    = (isr == 8'h00) ? 8'hFF : isr_low - 8'd1;
  assign cand     = pending & above;
  assign win_oh   = cand & (~cand + 8'd1);
  assign win_lvl  = enc(win_oh);
  assign spurious = cand == 8'h00;
  assign int_out  = ready && !spurious;

  assign cmd_wr   = wr_en && !addr;
  assign dat_wr   = wr_en && addr;
  assign init_cmd = cmd_wr && wdata[4];
  assign ocw_ok   = cmd_wr && !wdata[4] && ready;
  assign seoi     = ocw_ok && !wdata[3] && wdata[7:5] == 3'b011;
  assign neoi     = ocw_ok && !wdata[3] && wdata[7:5] == 3'b001;
  assign rsel     = ocw_ok && wdata[3] && wdata[1];
  assign eoi_mask = seoi ? (8'h01 << wdata[2:0]) : (neoi ? isr_low : 8'h00);

  assign ack_take = ack && ready && (is_master || cas_id_in == cas_word[2:0]);
  assign to_slave = is_master && |(win_oh & cas_word);
  assign set_isr  = (ack_take && !aeoi) ? win_oh : 8'h00;
  assign rise     = irq_in & ~prev_in;

  assign rdata = addr ? imr : (sel_isr ? isr : irr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seq        <= S_RDY;
      inited     <= 1'b0;
      need_mode  <= 1'b0;
      aeoi       <= 1'b0;
      sel_isr    <= 1'b0;
      imr        <= 8'h00;
      irr        <= 8'h00;
      isr        <= 8'h00;
      prev_in    <= 8'hFF;
      cas_word   <= 8'h00;
      base       <= 5'd0;
      vec_valid  <= 1'b0;
      vector     <= 8'h00;
      cas_drive  <= 1'b0;
      cas_id_out <= 3'd0;
    end else begin
      prev_in <= irq_in;
      if (init_cmd) begin
        seq       <= S_BASE;
        inited    <= 1'b0;
        need_mode <= wdata[0];
        sel_isr   <= 1'b0;
        imr       <= 8'h00;
        irr       <= 8'h00;
        isr       <= 8'h00;
        prev_in   <= 8'hFF;
      end else begin
        irr <= (irr | rise) & irq_in & ~(ack_take ? win_oh : 8'h00);
        isr <= (isr & ~eoi_mask) | set_isr;
        if (rsel) sel_isr <= wdata[0];
        if (dat_wr) begin
          unique case (seq)
            S_BASE: begin
              base <= wdata[7:3];
              seq  <= S_CAS;
            end
            S_CAS: begin
              cas_word <= wdata;
              if (need_mode) seq <= S_MODE;
              else begin
                seq    <= S_RDY;
                aeoi   <= 1'b0;
                inited <= 1'b1;
              end
            end
            S_MODE: begin
              aeoi   <= wdata[1];
              seq    <= S_RDY;
              inited <= 1'b1;
            end
            default: if (inited) imr <= wdata;
          endcase
        end
      end
      vec_valid  <= ack_take && !to_slave;
      cas_drive  <= ack_take && to_slave;
      cas_id_out <= (ack_take && to_slave) ? win_lvl : 3'd0;
      if (ack_take) vector <= {base, spurious ? 3'd7 : win_lvl};
    end
  end
endmodule

module prio_irq_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic       addr,
  input logic [7:0] wdata,
  input logic       ack,
  input logic       ready,
  input logic       aeoi,
  input logic       is_master,
  input logic [2:0] cas_id_in,
  input logic [7:0] cas_word,
  input logic [7:0] irr,
  input logic [7:0] imr,
  input logic [7:0] isr,
  input logic       int_out,
  input logic       vec_valid,
  input logic       cas_drive
);
  // R3
  int_needs_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int_out |-> |(irr & ~imr));
  // R5
  vec_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> $past(ack));
  // R6
  spec_eoi_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !addr && wdata[7:3] == 5'b01100 && ready && !ack) |=> !isr[$past(wdata[2:0])]);
  // R10
  auto_eoi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && aeoi && !wr_en) |=> isr == $past(isr));
  // R11
  cascade_no_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cas_drive |-> !vec_valid);
  // R12
  slave_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_master && ack && cas_id_in != cas_word[2:0]) |=> !vec_valid);
endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .ack(ack), .ready(ready), .aeoi(aeoi), .is_master(is_master),
  .cas_id_in(cas_id_in), .cas_word(cas_word), .irr(irr), .imr(imr),
  .isr(isr), .int_out(int_out), .vec_valid(vec_valid), .cas_drive(cas_drive)
);

// File: tb/prio_irq_ctrl_bench.sv
module prio_irq_ctrl_bench;
  logic       clk = 0, rst_n = 0, wr_en = 0, addr = 0, ack = 0, is_master = 1;
  logic [7:0] wdata = 0, irq_in = 0;
  logic [2:0] cas_id_in = 0;
  logic [7:0] rdata, vector;
  logic [2:0] cas_id_out;
  logic       int_out, cas_drive, vec_valid;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  prio_irq_ctrl u_prio_irq_ctrl (.*);

  // {is_read, addr, data, expected}; covers R2 and R8
  localparam logic [17:0] TBL [13] = '{
    {1'b0, 1'b0, 8'h11, 8'h00}, {1'b0, 1'b1, 8'h20, 8'h00},
    {1'b0, 1'b1, 8'h04, 8'h00}, {1'b0, 1'b1, 8'h01, 8'h00},
    {1'b1, 1'b1, 8'h00, 8'h00}, {1'b1, 1'b0, 8'h00, 8'h00},
    {1'b0, 1'b1, 8'hA5, 8'h00}, {1'b1, 1'b1, 8'h00, 8'hA5},
    {1'b0, 1'b0, 8'h0B, 8'h00}, {1'b1, 1'b0, 8'h00, 8'h00},
    {1'b0, 1'b0, 8'h0A, 8'h00}, {1'b0, 1'b1, 8'h00, 8'h00},
    {1'b1, 1'b1, 8'h00, 8'h00}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input string req, input logic a, input logic [7:0] exp);
    addr = a; #1; chk(req, rdata, exp);
  endtask

  task automatic irq(input int n, input logic v);
    @(negedge clk); irq_in[n] = v;
    @(negedge clk); #1;
  endtask

  task automatic pulse_ack;
    @(negedge clk); ack = 1;
    @(negedge clk); ack = 0; #1;
  endtask

  initial begin
    #1000000;
    fails++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1; #1;
    // R1 reset state
    chk("R1", {5'd0, int_out, vec_valid, cas_drive}, 8'h00);
    rd("R1", 0, 8'h00); rd("R1", 1, 8'h00);

    for (int i = 0; i < 13; i++) begin
      if (TBL[i][17]) rd("R2", TBL[i][16], TBL[i][7:0]);
      else wr(TBL[i][16], TBL[i][15:8]);
    end

    // R13 request recorded on rise, dropped on fall; R9 vanished request
    irq(3, 1); chk("R13", {7'd0, int_out}, 8'h01); rd("R13", 0, 8'h08);
    irq(3, 0); chk("R13", {7'd0, int_out}, 8'h00); rd("R13", 0, 8'h00);
    wr(1, 8'h80);
    pulse_ack; chk("R9", {7'd0, vec_valid}, 8'h01); chk("R9", vector, 8'h27);
    wr(0, 8'h0B); rd("R9", 0, 8'h00);
    wr(1, 8'h00);

    // R5 acknowledge
    irq(5, 1); pulse_ack;
    chk("R5", vector, 8'h25); rd("R5", 0, 8'h20);
    // R4 nesting
    irq(6, 1); chk("R4", {7'd0, int_out}, 8'h00);
    irq(1, 1); chk("R4", {7'd0, int_out}, 8'h01);
    pulse_ack; chk("R4", vector, 8'h21); rd("R4", 0, 8'h22);
    // R7 / R6
    wr(0, 8'h20); rd("R7", 0, 8'h20);
    wr(0, 8'h65); rd("R6", 0, 8'h00);
    // R3 masking
    wr(1, 8'h40); #1; chk("R3", {7'd0, int_out}, 8'h00);
    wr(1, 8'h00); #1; chk("R3", {7'd0, int_out}, 8'h01);
    pulse_ack; chk("R3", vector, 8'h26);
    wr(0, 8'h66);
    irq(1, 0); irq(5, 0); irq(6, 0);

    // R11 cascade routing on master
    irq(2, 1); pulse_ack;
    chk("R11", {4'd0, cas_drive, cas_id_out}, 8'h0A);
    chk("R11", {7'd0, vec_valid}, 8'h00); rd("R11", 0, 8'h04);
    wr(0, 8'h62); irq(2, 0);

    // same-cycle acknowledge and specific end of service
    irq(4, 1); pulse_ack; chk("R5", vector, 8'h24);
    irq(0, 1);
    @(negedge clk); ack = 1; addr = 0; wdata = 8'h64; wr_en = 1;
    @(negedge clk); ack = 0; wr_en = 0; #1;
    chk("R6", vector, 8'h20); rd("R6", 0, 8'h01);
    wr(0, 8'h60); irq(0, 0); irq(4, 0);

    // R10 auto end of service, R13 held input across setup
    irq(1, 1);
    wr(0, 8'h11); wr(1, 8'h20); wr(1, 8'h04); wr(1, 8'h03);
    rd("R13", 0, 8'h00); chk("R13", {7'd0, int_out}, 8'h00);
    irq(3, 1); pulse_ack; chk("R10", vector, 8'h23);
    wr(0, 8'h0B); rd("R10", 0, 8'h00);
    irq(3, 0); irq(1, 0);

    // R12 slave, three-word setup
    is_master = 0;
    wr(0, 8'h10); wr(1, 8'h28); wr(1, 8'h02);
    irq(4, 1);
    cas_id_in = 3'd5; pulse_ack;
    chk("R12", {7'd0, vec_valid}, 8'h00); rd("R12", 0, 8'h10);
    cas_id_in = 3'd2; pulse_ack;
    chk("R12", {7'd0, vec_valid}, 8'h01); chk("R12", vector, 8'h2C);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule